// File: doc/BRIEF.md
# Reversible Register Operation Unit

This block holds a small register file and applies one data operation per accepted request, under rules that never let a write quietly destroy information. Each request names an operation, a form (two-operand or three-operand), a destination index, one or two register source indices or an immediate, and whether the forward operation or its inverse ("un-" form) is wanted. An operation that would break the rules is refused. A refused request raises a one-cycle fault flag and leaves every register untouched.

Two-operand arithmetic folds the source into the destination, and its inverse undoes that step. Three-operand operations may only fill a destination that already holds zero. Their inverses may only clear a destination that still holds the value they recompute from the sources. Swap, copy and uncopy move values without loss. The only way to discard data is ERASE, which zeroes a register and adds the number of 1 bits it held to a running total. A read port returns any register's contents at any time.

Top module: `rev_regop_unit`

## Requirements
- R1: After reset every register reads 0, `fault` is low and `erased_bits` is 0.
- R2: Two-operand ADD (op_code 0), SUB (1) and XOR (2) set dst to dst+src, dst-src and dst^src. The source is register `srca_idx`, or `imm` when `use_imm`=1. The source is unchanged and the arithmetic is modulo 2^WIDTH. With `op_un`=1, ADD and SUB swap roles and XOR is its own inverse.
- R3: A two-operand request whose register source index equals `dst_idx` faults.
- R4: AND (3) and OR (4) in two-operand form (`op_three`=0) always fault.
- R5: Three-operand ADD, SUB, XOR, AND or OR writes `srca` op (`srcb` or `imm`) into dst if dst holds 0. A nonzero dst makes the request fault.
- R6: An inverse three-operand request clears dst when dst equals the recomputed result. Otherwise it faults.
- R7: A three-operand request whose dst index equals `srca_idx`, or equals `srcb_idx` when `use_imm`=0, faults.
- R8: EXCH (5) swaps registers dst and srca, and its inverse does the same. It faults in three-operand form or with an immediate.
- R9: COPY (6) writes the source (srca register or immediate) into a zero dst. It faults if dst is nonzero or the form is three-operand.
- R10: Inverse COPY clears dst when dst equals the source and faults otherwise.
- R11: ERASE (7) zeroes dst and adds the count of 1 bits it held to `erased_bits`, whatever the form. An inverse ERASE faults. Nothing else changes `erased_bits`.
- R12: A faulting request changes no register and no count, and `fault` is high for the cycle after it. After an accepted request `fault` is low.
- R13: With `op_valid` low, no register or count changes and `fault` is low on the next cycle.
- R14: Register 0 stores and returns values like any other register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Request present this cycle |
| op_code | input | 3 | Operation: 0 ADD, 1 SUB, 2 XOR, 3 AND, 4 OR, 5 EXCH, 6 COPY, 7 ERASE |
| op_un | input | 1 | Select the inverse form |
| op_three | input | 1 | 1 = three-operand form |
| use_imm | input | 1 | Second source is `imm` instead of a register |
| dst_idx | input | log2(NREG) | Destination register |
| srca_idx | input | log2(NREG) | First source register |
| srcb_idx | input | log2(NREG) | Second source register (three-operand) |
| imm | input | WIDTH | Immediate operand |
| rd_idx | input | log2(NREG) | Read port index |
| rd_data | output | WIDTH | Contents of register `rd_idx` |
| fault | output | 1 | Previous request was refused |
| erased_bits | output | CNT_W | Running total of discarded 1 bits |

## Verification
The assertions assume that `op_code`, `op_three`, `op_un`, `use_imm` and `dst_idx` are known whenever `op_valid` is high. They also assume `op_valid` is held low throughout reset, because several properties compare against the previous cycle's register contents. The bench drives every request field on the falling edge and pulses `op_valid` for a single cycle. It holds `op_valid` low during both resets it applies, and it changes request fields only while a request is not being accepted, except in the idle test.

// File: rtl/rev_pkg.sv
package rev_pkg;
    typedef enum logic [2:0] {
        ROP_ADD   = 3'd0,
        ROP_SUB   = 3'd1,
        ROP_XOR   = 3'd2,
        ROP_AND   = 3'd3,
        ROP_OR    = 3'd4,
        ROP_EXCH  = 3'd5,
        ROP_COPY  = 3'd6,
        ROP_ERASE = 3'd7
    } rop_e;
endpackage

// File: rtl/rev_alu.sv
module rev_alu
    import rev_pkg::*;
#(
    parameter int W = 16
) (
    input  rop_e         op,
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] r
);
    always_comb begin
        unique case (op)
            ROP_ADD: r = x + y;
            ROP_SUB: r = x - y;
            ROP_XOR: r = x ^ y;
            ROP_AND: r = x & y;
            ROP_OR:  r = x | y;
            default: r = y;      // copy-style ops pass the source through
        endcase
    end
endmodule

// File: rtl/rev_popcount.sv
module rev_popcount #(
    parameter int W  = 16,
    parameter int CW = 5
) (
    input  logic [W-1:0]  v,
    output logic [CW-1:0] n
);
    always_comb begin
        n = '0;
        for (int i = 0; i < W; i++) begin
            n = n + CW'(v[i]);
        end
    end
endmodule

// File: rtl/rev_legal.sv
module rev_legal
    import rev_pkg::*;
(
    input  rop_e op,
    input  logic un,
    input  logic three,
    input  logic use_imm,
    input  logic dst_eq_a,
    input  logic dst_eq_b,
    input  logic dst_zero,
    input  logic dst_match,
    output logic illegal
);
    logic alias_two;
    logic alias_three;
    logic guard_fail;

    always_comb begin
        alias_two   = dst_eq_a && !use_imm;
        alias_three = dst_eq_a || (dst_eq_b && !use_imm);
        // forward form needs an empty destination, inverse form needs a match
        guard_fail  = un ? !dst_match : !dst_zero;
        unique case (op)
            ROP_ADD, ROP_SUB, ROP_XOR:
                illegal = three ? (alias_three || guard_fail) : alias_two;
            ROP_AND, ROP_OR:
                illegal = !three || alias_three || guard_fail;
            ROP_EXCH:
                illegal = three || use_imm || dst_eq_a;
            ROP_COPY:
                illegal = three || alias_two || guard_fail;
            default:
                illegal = un;
        endcase
    end
endmodule

// File: rtl/rev_regop_unit.sv
module rev_regop_unit
    import rev_pkg::*;
#(
    parameter int NREG  = 8,
    parameter int WIDTH = 16,
    parameter int CNT_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       op_valid,
    input  logic [2:0]                 op_code,
    input  logic                       op_un,
    input  logic                       op_three,
    input  logic                       use_imm,
    input  logic [$clog2(NREG)-1:0]    dst_idx,
    input  logic [$clog2(NREG)-1:0]    srca_idx,
    input  logic [$clog2(NREG)-1:0]    srcb_idx,
    input  logic [WIDTH-1:0]           imm,
    input  logic [$clog2(NREG)-1:0]    rd_idx,
    output logic [WIDTH-1:0]           rd_data,
    output logic                       fault,
    output logic [CNT_W-1:0]           erased_bits
);
    localparam int PW = $clog2(WIDTH + 1);

    typedef struct packed {
        logic [NREG-1:0][WIDTH-1:0] regs;
        logic [CNT_W-1:0]           cnt;
        logic                       fault;
    } state_t;

    state_t s_d, s_q;
    logic [NREG-1:0][WIDTH-1:0] regs_q;

    rop_e             op;
    rop_e             alu_op;
    logic [WIDTH-1:0] val_d_reg, val_a, val_b, opnd1, opnd2, alu_r;
    logic [PW-1:0]    ones;
    logic             illegal;

    assign op        = rop_e'(op_code);
    assign regs_q    = s_q.regs;
    assign val_d_reg = regs_q[dst_idx];
    assign val_a     = regs_q[srca_idx];
    assign val_b     = regs_q[srcb_idx];
    assign opnd1     = op_three ? val_a : val_d_reg;
    assign opnd2     = op_three ? (use_imm ? imm : val_b) : (use_imm ? imm : val_a);

    // two-operand inverse of ADD is SUB and vice versa
    always_comb begin
        alu_op = op;
        if (!op_three && op_un) begin
            if (op == ROP_ADD)      alu_op = ROP_SUB;
            else if (op == ROP_SUB) alu_op = ROP_ADD;
        end
    end

    rev_alu #(.W(WIDTH)) u_alu (
        .op (alu_op),
        .x  (opnd1),
        .y  (opnd2),
        .r  (alu_r)
    );

    rev_popcount #(.W(WIDTH), .CW(PW)) u_pop (
        .v (val_d_reg),
        .n (ones)
    );

    rev_legal u_legal (
        .op        (op),
        .un        (op_un),
        .three     (op_three),
        .use_imm   (use_imm),
        .dst_eq_a  (dst_idx == srca_idx),
        .dst_eq_b  (dst_idx == srcb_idx),
        .dst_zero  (val_d_reg == '0),
        .dst_match (val_d_reg == alu_r),
        .illegal   (illegal)
    );

    always_comb begin
        s_d       = s_q;
        s_d.fault = 1'b0;
        if (op_valid) begin
            if (illegal) begin
                s_d.fault = 1'b1;
            end else begin
                unique case (op)
                    ROP_ERASE: begin
                        s_d.regs[dst_idx] = '0;
                        s_d.cnt           = s_q.cnt + CNT_W'(ones);
                    end
                    ROP_EXCH: begin
                        s_d.regs[dst_idx]  = val_a;
                        s_d.regs[srca_idx] = val_d_reg;
                    end
                    ROP_COPY: begin
                        s_d.regs[dst_idx] = op_un ? '0 : opnd2;
                    end
                    default: begin
                        s_d.regs[dst_idx] = (op_three && op_un) ? '0 : alu_r;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_data     = regs_q[rd_idx];
    assign fault       = s_q.fault;
    assign erased_bits = s_q.cnt;
endmodule

// File: rtl/rev_regop_checker.sv
module rev_regop_checker #(
    parameter int NREG  = 8,
    parameter int WIDTH = 16,
    parameter int CNT_W = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       op_valid,
    input logic [2:0]                 op_code,
    input logic                       op_un,
    input logic                       op_three,
    input logic [$clog2(NREG)-1:0]    dst_idx,
    input logic                       fault,
    input logic [CNT_W-1:0]           erased_bits,
    input logic [NREG-1:0][WIDTH-1:0] regs
);
    p_fault_freezes_regs_r12: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (regs == $past(regs) && erased_bits == $past(erased_bits)));

    p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(op_valid) |-> (!fault && regs == $past(regs)));

    p_count_only_erase_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (erased_bits != $past(erased_bits)) |-> $past(op_valid && op_code == 3'd7));

    p_erase_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(op_valid && op_code == 3'd7 && !op_un) |-> (regs[$past(dst_idx)] == '0));

    p_full_dst_faults_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(op_valid && op_three && !op_un && op_code <= 3'd4 && regs[dst_idx] != '0)
        |-> fault);

    p_two_op_logic_faults_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(op_valid && !op_three && (op_code == 3'd3 || op_code == 3'd4)) |-> fault);
endmodule

bind rev_regop_unit rev_regop_checker #(.NREG(NREG), .WIDTH(WIDTH), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_valid    (op_valid),
    .op_code     (op_code),
    .op_un       (op_un),
    .op_three    (op_three),
    .dst_idx     (dst_idx),
    .fault       (fault),
    .erased_bits (erased_bits),
    .regs        (regs_q)
);

// File: tb/rev_regop_unit_test.sv
module rev_regop_unit_test;
    localparam int NREG = 8, WIDTH = 16, CNT_W = 16, NV = 33;

    logic clk = 1'b0, rst_n = 1'b0;
    logic op_valid = 1'b0, op_un = 1'b0, op_three = 1'b0, use_imm = 1'b0;
    logic [2:0] op_code = '0, dst_idx = '0, srca_idx = '0, srcb_idx = '0, rd_idx = '0;
    logic [WIDTH-1:0] imm = '0;
    logic [WIDTH-1:0] rd_data;
    logic fault;
    logic [CNT_W-1:0] erased_bits;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    rev_regop_unit #(.NREG(NREG), .WIDTH(WIDTH), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_un(op_un), .op_three(op_three), .use_imm(use_imm),
        .dst_idx(dst_idx), .srca_idx(srca_idx), .srcb_idx(srcb_idx), .imm(imm),
        .rd_idx(rd_idx), .rd_data(rd_data), .fault(fault), .erased_bits(erased_bits)
    );

    localparam logic [2:0] ADD = 3'd0, SUB = 3'd1, XR = 3'd2, AN = 3'd3, OR_ = 3'd4,
                           EX = 3'd5, CP = 3'd6, ER = 3'd7;

    typedef struct packed {
        logic [2:0]  code;
        logic        un, three, im;
        logic [2:0]  d, a, b;
        logic [15:0] iv;
        logic        ef;
        logic [2:0]  ci;
        logic [15:0] ev;
        logic [3:0]  rq;
    } vec_t;

    // code un 3op imm d a b immv | exp_fault chk_reg exp_val | req
    localparam vec_t VEC [NV] = '{
        '{CP ,1'b0,1'b0,1'b1,3'd1,3'd0,3'd0,16'h0005, 1'b0,3'd1,16'h0005, 4'd9 },  // R9
        '{CP ,1'b0,1'b0,1'b1,3'd2,3'd0,3'd0,16'h0003, 1'b0,3'd2,16'h0003, 4'd9 },  // R9
        '{ADD,1'b0,1'b1,1'b0,3'd3,3'd1,3'd2,16'h0000, 1'b0,3'd3,16'h0008, 4'd5 },  // R5
        '{ADD,1'b0,1'b1,1'b0,3'd3,3'd1,3'd2,16'h0000, 1'b1,3'd3,16'h0008, 4'd5 },  // R5 full dst
        '{ADD,1'b1,1'b1,1'b0,3'd3,3'd1,3'd2,16'h0000, 1'b0,3'd3,16'h0000, 4'd6 },  // R6
        '{SUB,1'b0,1'b1,1'b1,3'd3,3'd1,3'd0,16'h0002, 1'b0,3'd3,16'h0003, 4'd5 },  // R5
        '{SUB,1'b1,1'b1,1'b1,3'd3,3'd1,3'd0,16'h0001, 1'b1,3'd3,16'h0003, 4'd6 },  // R6 mismatch
        '{SUB,1'b1,1'b1,1'b1,3'd3,3'd1,3'd0,16'h0002, 1'b0,3'd3,16'h0000, 4'd6 },  // R6
        '{AN ,1'b0,1'b1,1'b0,3'd4,3'd1,3'd2,16'h0000, 1'b0,3'd4,16'h0001, 4'd5 },  // R5
        '{OR_,1'b0,1'b1,1'b0,3'd5,3'd1,3'd2,16'h0000, 1'b0,3'd5,16'h0007, 4'd5 },  // R5
        '{OR_,1'b1,1'b1,1'b0,3'd5,3'd1,3'd2,16'h0000, 1'b0,3'd5,16'h0000, 4'd6 },  // R6
        '{AN ,1'b0,1'b0,1'b0,3'd4,3'd1,3'd0,16'h0000, 1'b1,3'd4,16'h0001, 4'd4 },  // R4
        '{OR_,1'b0,1'b0,1'b0,3'd1,3'd2,3'd0,16'h0000, 1'b1,3'd1,16'h0005, 4'd4 },  // R4
        '{ADD,1'b0,1'b0,1'b0,3'd1,3'd2,3'd0,16'h0000, 1'b0,3'd1,16'h0008, 4'd2 },  // R2
        '{XR ,1'b0,1'b0,1'b1,3'd1,3'd0,3'd0,16'h00F0, 1'b0,3'd1,16'h00F8, 4'd2 },  // R2
        '{XR ,1'b1,1'b0,1'b1,3'd1,3'd0,3'd0,16'h00F0, 1'b0,3'd1,16'h0008, 4'd2 },  // R2
        '{ADD,1'b1,1'b0,1'b0,3'd1,3'd2,3'd0,16'h0000, 1'b0,3'd1,16'h0005, 4'd2 },  // R2
        '{SUB,1'b0,1'b0,1'b1,3'd1,3'd0,3'd0,16'h0006, 1'b0,3'd1,16'hFFFF, 4'd2 },  // R2 wrap
        '{ADD,1'b0,1'b0,1'b1,3'd1,3'd0,3'd0,16'h0006, 1'b0,3'd1,16'h0005, 4'd2 },  // R2
        '{ADD,1'b0,1'b0,1'b0,3'd2,3'd2,3'd0,16'h0000, 1'b1,3'd2,16'h0003, 4'd3 },  // R3
        '{ADD,1'b0,1'b1,1'b0,3'd6,3'd6,3'd1,16'h0000, 1'b1,3'd6,16'h0000, 4'd7 },  // R7
        '{XR ,1'b0,1'b1,1'b0,3'd6,3'd1,3'd6,16'h0000, 1'b1,3'd6,16'h0000, 4'd7 },  // R7
        '{XR ,1'b0,1'b1,1'b0,3'd6,3'd1,3'd2,16'h0000, 1'b0,3'd6,16'h0006, 4'd5 },  // R5
        '{EX ,1'b0,1'b0,1'b0,3'd6,3'd0,3'd0,16'h0000, 1'b0,3'd0,16'h0006, 4'd14},  // R14 R8
        '{EX ,1'b1,1'b0,1'b0,3'd0,3'd6,3'd0,16'h0000, 1'b0,3'd6,16'h0006, 4'd8 },  // R8
        '{EX ,1'b0,1'b1,1'b0,3'd0,3'd6,3'd1,16'h0000, 1'b1,3'd0,16'h0000, 4'd8 },  // R8
        '{EX ,1'b0,1'b0,1'b1,3'd0,3'd6,3'd0,16'h0001, 1'b1,3'd0,16'h0000, 4'd8 },  // R8
        '{CP ,1'b0,1'b0,1'b1,3'd1,3'd0,3'd0,16'h0009, 1'b1,3'd1,16'h0005, 4'd9 },  // R9
        '{CP ,1'b0,1'b1,1'b0,3'd0,3'd1,3'd2,16'h0000, 1'b1,3'd0,16'h0000, 4'd9 },  // R9
        '{CP ,1'b0,1'b0,1'b0,3'd0,3'd1,3'd0,16'h0000, 1'b0,3'd0,16'h0005, 4'd14},  // R14 R9
        '{CP ,1'b1,1'b0,1'b0,3'd0,3'd2,3'd0,16'h0000, 1'b1,3'd0,16'h0005, 4'd10},  // R10
        '{CP ,1'b1,1'b0,1'b0,3'd0,3'd1,3'd0,16'h0000, 1'b0,3'd0,16'h0000, 4'd10},  // R10
        '{ER ,1'b1,1'b0,1'b0,3'd1,3'd0,3'd0,16'h0000, 1'b1,3'd1,16'h0005, 4'd11}   // R11
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] c, input logic u, input logic t, input logic im,
                         input logic [2:0] d, input logic [2:0] a, input logic [2:0] b,
                         input logic [15:0] iv, input logic [2:0] ci);
        op_code = c; op_un = u; op_three = t; use_imm = im;
        dst_idx = d; srca_idx = a; srcb_idx = b; imm = iv; op_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0;
        rd_idx = ci;
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 fault", 32'(fault), 32'd0);
        check("R1 count", 32'(erased_bits), 32'd0);
        for (int i = 0; i < NREG; i++) begin
            rd_idx = 3'(i); #1;
            check("R1 reg", 32'(rd_data), 32'd0);
        end

        for (int k = 0; k < NV; k++) begin
            issue(VEC[k].code, VEC[k].un, VEC[k].three, VEC[k].im,
                  VEC[k].d, VEC[k].a, VEC[k].b, VEC[k].iv, VEC[k].ci);
            check($sformatf("R%0d fault vec%0d", VEC[k].rq, k), 32'(fault), 32'(VEC[k].ef));
            check($sformatf("R%0d value vec%0d", VEC[k].rq, k), 32'(rd_data), 32'(VEC[k].ev));
        end

        // R12: faults left the count alone
        check("R12 count after faults", 32'(erased_bits), 32'd0);
        // R2: two-operand source untouched
        rd_idx = 3'd2; #1;
        check("R2 source kept", 32'(rd_data), 32'd3);

        // R13: idle cycle with junk on the request fields
        op_code = ER; dst_idx = 3'd2; op_un = 1'b0; op_valid = 1'b0;
        @(posedge clk); @(negedge clk); rd_idx = 3'd2; #1;
        check("R13 idle reg", 32'(rd_data), 32'd3);
        check("R13 idle fault", 32'(fault), 32'd0);
        check("R13 idle count", 32'(erased_bits), 32'd0);

        // R11 erase counting (r6=6 two ones, r1=5 two ones, r0=0)
        issue(ER, 1'b0, 1'b0, 1'b0, 3'd6, 3'd0, 3'd0, 16'h0, 3'd6);
        check("R11 erase zero", 32'(rd_data), 32'd0);
        check("R11 count 2", 32'(erased_bits), 32'd2);
        check("R12 fault low", 32'(fault), 32'd0);
        issue(ER, 1'b0, 1'b1, 1'b0, 3'd1, 3'd0, 3'd0, 16'h0, 3'd1);
        check("R11 erase 3op form", 32'(rd_data), 32'd0);
        check("R11 count 4", 32'(erased_bits), 32'd4);
        issue(ER, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 3'd0, 16'h0, 3'd0);
        check("R11 empty erase", 32'(erased_bits), 32'd4);
        issue(ER, 1'b1, 1'b0, 1'b0, 3'd2, 3'd0, 3'd0, 16'h0, 3'd2);
        check("R11 un erase fault", 32'(fault), 32'd1);
        check("R12 count frozen", 32'(erased_bits), 32'd4);
        check("R12 reg frozen", 32'(rd_data), 32'd3);

        // R1 reset again mid-run
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        rst_n = 1'b1; rd_idx = 3'd2; #1;
        check("R1 reset reg", 32'(rd_data), 32'd0);
        check("R1 reset count", 32'(erased_bits), 32'd0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule